// File: doc/BRIEF.md
# Register-Mapped Single-Word SPI Master

This block is a serial peripheral interface master that software drives through a small word-addressed register file. Software first sets the clock mode, the word width and the bit orders in a configuration register. It then writes a word to the transmit-data register. That write starts one full-duplex exchange of 8 or 16 bits. When the last bit has been captured, a completion flag is raised in the event register. Software polls that flag, reads the received word from the receive-data register, and clears the flag by writing to the event register before it sends the next word.

The select lines are driven from an encoded 3-bit line index and a separate enable bit, so at most one active-low select output can be low at any time. The serial clock runs at a fixed fraction of the system clock, set by the `HALF` parameter: each level of the serial clock lasts `HALF` system clocks, and `HALF` must be at least 4. A two-bit capture-delay field chooses how many system clocks after the sampling edge the input line is latched. A larger delay lets a slow slave meet timing in the fast modes.

Top module: `spi_regmaster`

## Requirements
- R1: After reset, control, configuration, data-out, data-in and event read 0, the timing register reads 0x40 (delay 1), every select output is high, SCK is low and MOSI is low.
- R2: Register offsets are control 0x00, configuration 0x04, data-out 0x08, data-in 0x0C, event 0x10 and timing 0x18. Control keeps only bit 0 (select enable) and bits [4:2] (line index). Configuration keeps only bit 5 (16-bit words), bit 11 (CPOL), bit 12 (CPHA), bit 13 (transmit LSB-first) and bit 14 (receive LSB-first). Timing keeps only bits [7:6] (capture delay). Every other bit reads 0.
- R3: Select output k is low exactly when control bit 0 is set and bits [4:2] equal k, one clock after the control write. All other outputs are high.
- R4: A write to data-out while idle starts one exchange of 8 bits, or 16 bits when configuration bit 5 is set. When the exchange ends, event bit 0 reads 1. Any write to the event offset clears it.
- R5: With CPHA=0 the slave may sample MOSI on the leading SCK edge. With CPHA=1 it may sample on the trailing edge. The master samples MISO on the same edge the slave samples on.
- R6: Configuration bit 13 sends the transmit word LSB-first instead of MSB-first. Bit 14 places received bits LSB-first instead of MSB-first. The two bits act independently.
- R7: With capture delay d in timing bits [7:6], MISO is latched d system clocks after the clock edge on which SCK moves to its sampling level.
- R8: A write to data-out during an exchange is ignored. It changes neither the word on MOSI nor the data-out readback, and it starts no further exchange.
- R9: Data-in keeps its value until the next exchange completes. Writes to the data-in or event offsets do not change it.
- R10: Between exchanges, MOSI is low and SCK sits at the CPOL level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr, registered one clock later |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 8 | Active-low select lines |

## Verification
The capture-delay field is the hardest behaviour to observe from the ports. A slave that holds MISO steady for a whole SCK phase gives the same received word for every delay value. The bench therefore switches to a pattern slave. On each sampling edge, this slave drives the correct bit. One system clock later it drives the complement of that bit. Delay 1 must then return the pattern word, and delays 2 and 3 must return its complement. Ignored writes are reached by issuing a second data-out write only a few clocks after the first. The bench then checks that the bits on MOSI, the bit count, the data-out readback and the event flag all belong to the first word only.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam logic [4:0] OFS_CTRL   = 5'h00;
  localparam logic [4:0] OFS_CFG    = 5'h04;
  localparam logic [4:0] OFS_DOUT   = 5'h08;
  localparam logic [4:0] OFS_DIN    = 5'h0C;
  localparam logic [4:0] OFS_EVENT  = 5'h10;
  localparam logic [4:0] OFS_TIMING = 5'h18;

  localparam int B_SEL_EN  = 0;
  localparam int B_SEL_IDX = 2;
  localparam int B_WIDE    = 5;
  localparam int B_DLY     = 6;
  localparam int B_CPOL    = 11;
  localparam int B_CPHA    = 12;
  localparam int B_TX_LSB  = 13;
  localparam int B_RX_LSB  = 14;

  typedef struct packed {
    logic       wide;
    logic       cpol;
    logic       cpha;
    logic       tx_lsb;
    logic       rx_lsb;
    logic [1:0] sdly;
  } spim_cfg_t;

endpackage

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int WORD_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              xfer_done,
  input  logic [WORD_W-1:0] rx_word,
  output logic              start,
  output logic [WORD_W-1:0] start_word,
  output spim_cfg_t         cfg,
  output logic              sel_en,
  output logic [IDX_W-1:0]  sel_idx
);

  logic [WORD_W-1:0] dout_q;
  logic              event_q;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_hi;

  wire wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  wire wr_cfg   = bus_wr && (bus_addr == ADDR_W'(OFS_CFG));
  wire wr_dout  = bus_wr && (bus_addr == ADDR_W'(OFS_DOUT));
  wire wr_event = bus_wr && (bus_addr == ADDR_W'(OFS_EVENT));
  wire wr_tim   = bus_wr && (bus_addr == ADDR_W'(OFS_TIMING));

  assign start      = wr_dout && !busy;
  assign start_word = bus_wdata[WORD_W-1:0];
  assign unused_hi  = ^bus_wdata[DATA_W-1:WORD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_en  <= 1'b0;
      sel_idx <= '0;
      cfg     <= '{wide: 1'b0, cpol: 1'b0, cpha: 1'b0, tx_lsb: 1'b0,
                   rx_lsb: 1'b0, sdly: 2'd1};
      dout_q  <= '0;
      event_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        sel_en  <= bus_wdata[B_SEL_EN];
        sel_idx <= bus_wdata[B_SEL_IDX +: IDX_W];
      end
      if (wr_cfg) begin
        cfg.wide   <= bus_wdata[B_WIDE];
        cfg.cpol   <= bus_wdata[B_CPOL];
        cfg.cpha   <= bus_wdata[B_CPHA];
        cfg.tx_lsb <= bus_wdata[B_TX_LSB];
        cfg.rx_lsb <= bus_wdata[B_RX_LSB];
      end
      if (wr_tim)
        cfg.sdly <= bus_wdata[B_DLY +: 2];
      if (start)
        dout_q <= bus_wdata[WORD_W-1:0];
      if (xfer_done)
        event_q <= 1'b1;
      else if (wr_event)
        event_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      ADDR_W'(OFS_CTRL): begin
        rd_mux[B_SEL_EN]             = sel_en;
        rd_mux[B_SEL_IDX +: IDX_W]   = sel_idx;
      end
      ADDR_W'(OFS_CFG): begin
        rd_mux[B_WIDE]   = cfg.wide;
        rd_mux[B_CPOL]   = cfg.cpol;
        rd_mux[B_CPHA]   = cfg.cpha;
        rd_mux[B_TX_LSB] = cfg.tx_lsb;
        rd_mux[B_RX_LSB] = cfg.rx_lsb;
      end
      ADDR_W'(OFS_DOUT):   rd_mux[WORD_W-1:0] = dout_q;
      ADDR_W'(OFS_DIN):    rd_mux[WORD_W-1:0] = rx_word;
      ADDR_W'(OFS_EVENT):  rd_mux[0]          = event_q;
      ADDR_W'(OFS_TIMING): rd_mux[B_DLY +: 2] = cfg.sdly;
      default:             rd_mux             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  // R8: a data-out write that lands mid-exchange leaves the stored word alone
  p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_dout && busy) |=> $stable(dout_q));

  // R4: the completion pulse from the shifter always raises the event flag
  p_event_raised_r4: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> event_q);

endmodule

// File: rtl/spim_seldec.sv
module spim_seldec #(
  parameter int N_SEL = 8,
  parameter int IDX_W = $clog2(N_SEL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_en,
  input  logic [IDX_W-1:0] sel_idx,
  output logic [N_SEL-1:0] sel_n
);

  for (genvar g = 0; g < N_SEL; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) sel_n[g] <= 1'b1;
      else     sel_n[g] <= !(sel_en && (sel_idx == IDX_W'(g)));
    end
  end

  // R3: never more than one line low
  p_sel_single_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(~sel_n) <= 1);

  // R3: enabled index drives its own line low on the next clock
  p_sel_follow_r3: assert property (@(posedge clk) disable iff (rst)
    sel_en |=> !sel_n[$past(sel_idx)]);

  // R3: enable clear releases every line
  p_sel_release_r3: assert property (@(posedge clk) disable iff (rst)
    !sel_en |=> (&sel_n));

endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8,
  parameter int HALF     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] start_word,
  input  spim_cfg_t         cfg,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);

  localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int EC_W = $clog2(2 * WORD_W + 1);
  localparam int RI_W = $clog2(WORD_W);

  logic              run;
  logic [HC_W-1:0]   hc;
  logic [EC_W-1:0]   ec;
  logic [RI_W-1:0]   rxc;
  logic              wide_q, cpha_q, rxl_q;
  logic [1:0]        sdly_q;
  logic [WORD_W-1:0] tx_ser, rx_ser, ser_in, rx_asm;
  logic [2:0]        samp_pipe;
  logic [EC_W-1:0]   nbits, nedges, drive_idx;
  logic              tick, edge_go, leading, samp_now, cap;

  assign busy      = run;
  assign nbits     = wide_q ? EC_W'(WORD_W) : EC_W'(NARROW_W);
  assign nedges    = nbits << 1;
  assign tick      = run && (hc == HC_W'(HALF - 1));
  assign edge_go   = tick && (ec < nedges);
  assign leading   = !ec[0];
  assign samp_now  = edge_go && (leading ^ cpha_q);
  assign drive_idx = (ec >> 1) + (cpha_q ? EC_W'(0) : EC_W'(1));

  always_comb begin
    unique case (sdly_q)
      2'd0:    cap = samp_now;
      2'd1:    cap = samp_pipe[0];
      2'd2:    cap = samp_pipe[1];
      default: cap = samp_pipe[2];
    endcase
  end

  // Serial-order views: element i is the i-th bit on the wire
  for (genvar gj = 0; gj < WORD_W; gj++) begin : g_bit
    if (gj < NARROW_W) begin : g_lo
      assign ser_in[gj] = cfg.tx_lsb ? start_word[gj] :
                          (cfg.wide ? start_word[WORD_W-1-gj] : start_word[NARROW_W-1-gj]);
      assign rx_asm[gj] = rxl_q ? rx_ser[gj] :
                          (wide_q ? rx_ser[WORD_W-1-gj] : rx_ser[NARROW_W-1-gj]);
    end else begin : g_hi
      assign ser_in[gj] = cfg.tx_lsb ? start_word[gj] : start_word[WORD_W-1-gj];
      assign rx_asm[gj] = wide_q && (rxl_q ? rx_ser[gj] : rx_ser[WORD_W-1-gj]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      hc        <= '0;
      ec        <= '0;
      rxc       <= '0;
      wide_q    <= 1'b0;
      cpha_q    <= 1'b0;
      rxl_q     <= 1'b0;
      sdly_q    <= 2'd1;
      tx_ser    <= '0;
      rx_ser    <= '0;
      samp_pipe <= '0;
      sck       <= 1'b0;
      mosi      <= 1'b0;
      done      <= 1'b0;
      rx_word   <= '0;
    end else begin
      done      <= 1'b0;
      samp_pipe <= {samp_pipe[1:0], samp_now};
      if (cap) begin
        rx_ser[rxc] <= miso;
        rxc         <= rxc + 1'b1;
      end
      if (!run) begin
        sck <= cfg.cpol;
        if (start) begin
          run    <= 1'b1;
          hc     <= '0;
          ec     <= '0;
          rxc    <= '0;
          wide_q <= cfg.wide;
          cpha_q <= cfg.cpha;
          rxl_q  <= cfg.rx_lsb;
          sdly_q <= cfg.sdly;
          tx_ser <= ser_in;
          mosi   <= cfg.cpha ? 1'b0 : ser_in[0];
        end
      end else begin
        hc <= tick ? '0 : hc + 1'b1;
        if (edge_go) begin
          sck <= ~sck;
          ec  <= ec + 1'b1;
          if (!samp_now && (drive_idx < nbits))
            mosi <= tx_ser[drive_idx[RI_W-1:0]];
        end else if (tick) begin
          run     <= 1'b0;
          done    <= 1'b1;
          mosi    <= 1'b0;
          rx_word <= rx_asm;
        end
      end
    end
  end

  // R10: MOSI rests low whenever no exchange is running
  p_mosi_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !run |-> !mosi);

  // R4: the end of an exchange is always flagged
  p_end_flagged_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |-> done);

  // R4: an exchange ends only after two edges per bit
  p_edge_total_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (ec == nedges));

  // R9: received word changes only with a completion
  p_rx_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_word) |-> done);

endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
  import spim_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8,
  parameter int N_SEL    = 8,
  parameter int HALF     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [N_SEL-1:0]  spi_cs_n
);

  localparam int IDX_W = $clog2(N_SEL);

  spim_cfg_t         cfg;
  logic              start, busy, done, sel_en;
  logic [IDX_W-1:0]  sel_idx;
  logic [WORD_W-1:0] start_word, rx_word;

  spim_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .xfer_done(done), .rx_word(rx_word),
    .start(start), .start_word(start_word), .cfg(cfg),
    .sel_en(sel_en), .sel_idx(sel_idx)
  );

  spim_seldec #(.N_SEL(N_SEL), .IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst(rst), .sel_en(sel_en), .sel_idx(sel_idx), .sel_n(spi_cs_n)
  );

  spim_shift #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .HALF(HALF)) u_shift (
    .clk(clk), .rst(rst), .start(start), .start_word(start_word), .cfg(cfg),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .busy(busy), .done(done),
    .rx_word(rx_word)
  );

endmodule

// File: tb/spi_regmaster_tb.sv
module spi_regmaster_tb;
  import spim_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sck, mosi, miso;
  logic [7:0]  cs_n;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  // bench-side slave: loopback, or pattern that flips one clock after each rising edge
  logic        dly_mode = 1'b0;
  logic        pat = 1'b0;
  logic        pat_pend = 1'b0;
  logic [7:0]  pat_word = '0;
  int          pat_k = 0;
  logic        prev_sck = 1'b0;
  logic        mcpol = 1'b0, mcpha = 1'b0;
  logic [15:0] mon_bits = '0;
  int          mon_n = 0;

  assign miso = dly_mode ? pat : mosi;

  always @(negedge clk) begin
    if (sck !== prev_sck) begin
      if (((prev_sck == mcpol) != mcpha) && mon_n < 16) begin
        mon_bits[mon_n] = mosi;
        mon_n = mon_n + 1;
      end
      if (dly_mode && sck && !prev_sck && pat_k < 8) begin
        pat = pat_word[7 - pat_k];
        pat_k = pat_k + 1;
        pat_pend = 1'b1;
      end
    end else if (pat_pend) begin
      pat = ~pat;
      pat_pend = 1'b0;
    end
    prev_sck = sck;
  end

  spi_regmaster u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [15:0] ser(input logic [15:0] w, input int n, input logic lsb);
    logic [15:0] s = '0;
    for (int i = 0; i < n; i++) s[i] = lsb ? w[i] : w[n-1-i];
    return s;
  endfunction

  function automatic logic [15:0] exp_rx(input logic [15:0] w, input int n,
                                         input logic txl, input logic rxl);
    logic [15:0] s = ser(w, n, txl);
    logic [15:0] r = '0;
    for (int i = 0; i < n; i++) begin
      if (rxl) r[i] = s[i];
      else     r[n-1-i] = s[i];
    end
    return r;
  endfunction

  task automatic wait_done(input string req);
    logic [31:0] v = '0;
    for (int i = 0; i < 500; i++) begin
      bus_read(OFS_EVENT, v);
      if (v != 0) break;
    end
    chk(req, v, 32'h1);
  endtask

  task automatic xfer(input logic [15:0] w, output logic [15:0] r);
    logic [31:0] v;
    bus_write(OFS_EVENT, 32'h0);
    mon_n = 0; pat_k = 0; mon_bits = '0;
    bus_write(OFS_DOUT, {16'h0, w});
    wait_done("R4 completion flag");
    bus_read(OFS_DIN, v);
    r = v[15:0];
  endtask

  task automatic set_cfg(input logic wide, cpol, cpha, txl, rxl);
    logic [31:0] c = '0;
    c[B_WIDE] = wide; c[B_CPOL] = cpol; c[B_CPHA] = cpha;
    c[B_TX_LSB] = txl; c[B_RX_LSB] = rxl;
    mcpol = cpol; mcpha = cpha;
    bus_write(OFS_CFG, c);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 cs_n", {24'h0, cs_n}, 32'hFF);
    chk("R1 sck", {31'h0, sck}, 32'h0);
    chk("R1 mosi", {31'h0, mosi}, 32'h0);
    bus_read(OFS_CTRL, v);   chk("R1 control", v, 32'h0);
    bus_read(OFS_CFG, v);    chk("R1 config", v, 32'h0);
    bus_read(OFS_DOUT, v);   chk("R1 data-out", v, 32'h0);
    bus_read(OFS_DIN, v);    chk("R1 data-in", v, 32'h0);
    bus_read(OFS_EVENT, v);  chk("R1 event", v, 32'h0);
    bus_read(OFS_TIMING, v); chk("R1 timing", v, 32'h40);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    bus_write(OFS_CFG, 32'hFFFF_FFFF);
    bus_read(OFS_CFG, v);    chk("R2 config mask", v, 32'h0000_7820);
    bus_write(OFS_CFG, 32'h0000_2800);
    bus_read(OFS_CFG, v);    chk("R2 config partial", v, 32'h0000_2800);
    bus_write(OFS_CTRL, 32'hFFFF_FFFF);
    bus_read(OFS_CTRL, v);   chk("R2 control mask", v, 32'h1D);
    bus_write(OFS_TIMING, 32'hFFFF_FFFF);
    bus_read(OFS_TIMING, v); chk("R2 timing mask", v, 32'hC0);
    bus_write(OFS_TIMING, 32'h40);
    bus_write(OFS_CTRL, 32'h0);
    bus_write(OFS_CFG, 32'h0);
  endtask

  task automatic t_sel();
    for (int k = 0; k < 8; k++) begin
      bus_write(OFS_CTRL, (k << 2) | 1);
      @(negedge clk);
      chk("R3 select line", {24'h0, cs_n}, {24'h0, ~(8'h1 << k)});
    end
    bus_write(OFS_CTRL, 32'h14);
    @(negedge clk);
    chk("R3 enable clear", {24'h0, cs_n}, 32'hFF);
  endtask

  task automatic t_modes();
    logic [15:0] r, w;
    for (int m = 0; m < 4; m++) begin
      set_cfg(1'b0, m[1], m[0], 1'b0, 1'b0);
      chk("R10 sck idle level", {31'h0, sck}, {31'h0, m[1]});
      chk("R10 mosi idle", {31'h0, mosi}, 32'h0);
      w = 16'h00A5 ^ (16'h0013 * m[15:0]);
      xfer(w, r);
      chk("R5 loopback word", {16'h0, r}, {24'h0, w[7:0]});
      chk("R5 mosi at sample edge", {16'h0, mon_bits}, {16'h0, ser(w, 8, 1'b0)});
      chk("R4 eight bits", mon_n, 8);
      chk("R10 sck back to idle", {31'h0, sck}, {31'h0, m[1]});
      chk("R10 mosi low after", {31'h0, mosi}, 32'h0);
    end
  endtask

  task automatic t_wide();
    logic [15:0] r;
    set_cfg(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    xfer(16'hC3A1, r);
    chk("R4 sixteen-bit word", {16'h0, r}, 32'hC3A1);
    chk("R4 sixteen bits", mon_n, 16);
    chk("R4 sixteen-bit order", {16'h0, mon_bits}, {16'h0, ser(16'hC3A1, 16, 1'b0)});
  endtask

  task automatic t_order();
    logic [15:0] r;
    set_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    xfer(16'h0031, r);
    chk("R6 tx lsb-first wire", {16'h0, mon_bits}, {16'h0, ser(16'h0031, 8, 1'b1)});
    chk("R6 tx lsb rx msb", {16'h0, r}, {16'h0, exp_rx(16'h0031, 8, 1'b1, 1'b0)});
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    xfer(16'h00C6, r);
    chk("R6 tx msb rx lsb", {16'h0, r}, {16'h0, exp_rx(16'h00C6, 8, 1'b0, 1'b1)});
    set_cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    xfer(16'h005E, r);
    chk("R6 both lsb", {16'h0, r}, 32'h5E);
    set_cfg(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    xfer(16'h1F02, r);
    chk("R6 sixteen-bit tx lsb", {16'h0, r}, {16'h0, exp_rx(16'h1F02, 16, 1'b1, 1'b0)});
  endtask

  task automatic t_delay();
    logic [15:0] r;
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    dly_mode = 1'b1;
    pat_word = 8'h5A;
    bus_write(OFS_TIMING, 32'h40);
    xfer(16'h0000, r);
    chk("R7 delay 1 sees drive", {16'h0, r}, 32'h5A);
    bus_write(OFS_TIMING, 32'h80);
    xfer(16'h0000, r);
    chk("R7 delay 2 sees flip", {16'h0, r}, 32'hA5);
    bus_write(OFS_TIMING, 32'hC0);
    xfer(16'h0000, r);
    chk("R7 delay 3 sees flip", {16'h0, r}, 32'hA5);
    dly_mode = 1'b0;
    bus_write(OFS_TIMING, 32'h40);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_write(OFS_EVENT, 32'h0);
    mon_n = 0; mon_bits = '0;
    bus_write(OFS_DOUT, 32'h3C);
    bus_write(OFS_DOUT, 32'hF0);
    bus_read(OFS_EVENT, v);
    chk("R4 event low mid-exchange", v, 32'h0);
    wait_done("R8 first word completes");
    bus_read(OFS_DIN, v);
    chk("R8 received first word", v, 32'h3C);
    bus_read(OFS_DOUT, v);
    chk("R8 data-out unchanged", v, 32'h3C);
    chk("R8 wire bits first word", {16'h0, mon_bits}, {16'h0, ser(16'h3C, 8, 1'b0)});
    bus_write(OFS_EVENT, 32'h0);
    repeat (100) @(negedge clk);
    bus_read(OFS_EVENT, v);
    chk("R8 no second exchange", v, 32'h0);
    chk("R8 bit count", mon_n, 8);
  endtask

  task automatic t_hold();
    logic [15:0] r;
    logic [31:0] v;
    xfer(16'h0069, r);
    bus_write(OFS_DIN, 32'h1234);
    bus_write(OFS_EVENT, 32'hFFFF);
    repeat (50) @(negedge clk);
    bus_read(OFS_DIN, v);
    chk("R9 data-in held", v, 32'h69);
    bus_read(OFS_EVENT, v);
    chk("R4 event cleared by write", v, 32'h0);
    xfer(16'h0096, r);
    chk("R9 data-in updates", {16'h0, r}, 32'h96);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_sel();
    t_modes();
    t_wide();
    t_order();
    t_delay();
    t_busy();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule